// File: doc/BRIEF.md
# GPIO port with peripheral direction override

This block is an eight-pin general-purpose I/O port for a larger chip. Software reaches three locations through a simple read/write bus: a direction register, an output data latch and a synchronized view of the pad levels. Each pin normally drives its data latch bit onto the pad when its direction bit is 1. When the direction bit is 0, the pin is an input.

Three on-chip peripherals can take over pins:

- A CAN channel on pins 7 and 6.
- An I2C channel on pins 7 and 6.
- A UART channel on pins 1 and 0.

While a peripheral is enabled on a pin, it decides that pin's direction and output value. The stored direction bits are never changed by this. When the peripheral is disabled, the stored bits control the pin again.

Each pin has an ownership selector, resolved every cycle with no memory. It takes one of four states:

- `OWN_CAN`: the CAN channel is enabled and the pin is one of its pins.
- `OWN_I2C`: the I2C channel is enabled on its pin and the CAN channel is not.
- `OWN_UART`: the UART transmit enable is set on the transmit pin, or the UART receive enable is set on the receive pin.
- `OWN_REG`: no peripheral claims the pin.

The ownership transitions follow the enables directly, with priority CAN, then I2C, then UART, then the register. When every enable is cleared, ownership falls back to `OWN_REG`.

Top module: `gpio_ovr_port`

## Requirements
- R1: While reset is asserted and after it is released, the direction register and the data latch are 0. All pad output enables are therefore 0.
- R2: When a pin is owned by the register, pad_oe equals its direction bit (1 = output, 0 = input) and pad_out equals its data latch bit.
- R3: Direction bit 3 is not implemented. It always reads 0, ignores writes, and pin 3's pad_oe stays 0 when no peripheral claims pin 3.
- R4: Address map: 0 = direction, 1 = port data, 2 = synchronized input, 3 = reads 0. Writes to addresses 0 and 1 take effect at the next clock edge. Reads are combinational and allowed at any time.
- R5: With can_en = 1, pin 7 has pad_oe = 1 and pad_out = can_tx. Pin 6 has pad_oe = 0 and pad_out = 0.
- R6: With i2c_en = 1, pins 7 and 6 take pad_oe and pad_out from i2c_oe and i2c_out. Bit 1 of each of these inputs maps to pin 7 and bit 0 maps to pin 6.
- R7: The UART is judged per pin. uart_tx_en = 1 forces pin 1 to pad_oe = 1 and pad_out = uart_tx. uart_rx_en = 1 forces pin 0 to pad_oe = 0 and pad_out = 0. A pin whose UART function is off stays with the register.
- R8: When both the CAN and I2C channels are enabled, the CAN channel owns pins 7 and 6.
- R9: Peripheral overrides never change the stored direction bits. Direction reads back unchanged, and when the peripheral is disabled the pin returns to its stored direction.
- R10: A pad level change appears at address 2 after exactly two clock edges. After one edge, the old level still reads back.
- R11: A read of address 1 returns the data latch bit for pins whose pad_oe is 1, and the synchronized pad level for pins whose pad_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write location |
| wr_data | input | 8 | Write value |
| rd_addr | input | 2 | Read location |
| rd_data | output | 8 | Read value |
| pad_in | input | 8 | Pad levels |
| pad_out | output | 8 | Pad drive values |
| pad_oe | output | 8 | Pad output enables |
| can_en | input | 1 | CAN channel enable |
| can_tx | input | 1 | CAN transmit value |
| i2c_en | input | 1 | I2C channel enable |
| i2c_oe | input | 2 | I2C output enables (bit 1 = pin 7) |
| i2c_out | input | 2 | I2C output values (bit 1 = pin 7) |
| uart_tx_en | input | 1 | UART transmit enable |
| uart_rx_en | input | 1 | UART receive enable |
| uart_tx | input | 1 | UART transmit value |

## Verification
Register writes are due one clock edge after the write strobe, and the bench checks them at the following falling edge. Pad output and output-enable results follow the peripheral inputs with no clock, so they are sampled shortly after the inputs change. The input view is due exactly two edges after a pad change. The bench samples it after the first edge to confirm the old value and after the second to confirm the new one.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

    typedef enum logic [1:0] {
        OWN_REG  = 2'd0,
        OWN_UART = 2'd1,
        OWN_I2C  = 2'd2,
        OWN_CAN  = 2'd3
    } pin_owner_e;

    localparam logic [1:0] ADDR_DIR   = 2'd0;
    localparam logic [1:0] ADDR_DATA  = 2'd1;
    localparam logic [1:0] ADDR_INPUT = 2'd2;

endpackage

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
    import gpio_ovr_pkg::*;
#(
    parameter int          WIDTH       = 8,
    parameter logic [WIDTH-1:0] UNIMPL_MASK = 8'h08
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] dat_q
);

    localparam logic [WIDTH-1:0] IMPL_MASK = ~UNIMPL_MASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            dat_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_DIR:  dir_q <= wr_data & IMPL_MASK;
                ADDR_DATA: dat_q <= wr_data;
                default: ;
            endcase
        end
    end

    // R4 / R3: a direction write lands at the next edge, unimplemented bits cleared
    p_dir_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_DIR) |=> (dir_q == ($past(wr_data) & IMPL_MASK)));

    // R9: nothing but a direction write can change the stored direction
    p_dir_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADDR_DIR) |=> $stable(dir_q));

endmodule

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] sync_q
);

    logic [WIDTH-1:0] stage1_q;
    logic [1:0]       warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            sync_q   <= '0;
            warm_q   <= '0;
        end else begin
            stage1_q <= pad_in;
            sync_q   <= stage1_q;
            if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
        end
    end

    // R10: the synchronized view equals the pad level from two edges earlier
    p_sync_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (sync_q == $past(pad_in, 2)));

endmodule

// File: rtl/gpio_ovr_pin.sv
module gpio_ovr_pin
    import gpio_ovr_pkg::*;
#(
    parameter int PIN         = 0,
    parameter int CAN_TX_PIN  = 7,
    parameter int CAN_RX_PIN  = 6,
    parameter int I2C_PIN_LO  = 6,
    parameter int I2C_PIN_HI  = 7,
    parameter int UART_TX_PIN = 1,
    parameter int UART_RX_PIN = 0
) (
    input  logic       dir_bit,
    input  logic       dat_bit,
    input  logic       can_en,
    input  logic       can_tx,
    input  logic       i2c_en,
    input  logic [1:0] i2c_oe,
    input  logic [1:0] i2c_out,
    input  logic       uart_tx_en,
    input  logic       uart_rx_en,
    input  logic       uart_tx,
    output logic       pad_out,
    output logic       pad_oe,
    output pin_owner_e owner
);

    localparam bit IS_CAN_TX  = (PIN == CAN_TX_PIN);
    localparam bit IS_CAN     = IS_CAN_TX || (PIN == CAN_RX_PIN);
    localparam bit IS_I2C     = (PIN == I2C_PIN_LO) || (PIN == I2C_PIN_HI);
    localparam int I2C_IDX    = (PIN == I2C_PIN_HI) ? 1 : 0;
    localparam bit IS_UART_TX = (PIN == UART_TX_PIN);
    localparam bit IS_UART_RX = (PIN == UART_RX_PIN);

    // ownership selection: CAN, then I2C, then UART, then the register
    always_comb begin
        if (IS_CAN && can_en)
            owner = OWN_CAN;
        else if (IS_I2C && i2c_en)
            owner = OWN_I2C;
        else if ((IS_UART_TX && uart_tx_en) || (IS_UART_RX && uart_rx_en))
            owner = OWN_UART;
        else
            owner = OWN_REG;
    end

    always_comb begin
        unique case (owner)
            OWN_CAN: begin
                pad_oe  = IS_CAN_TX;
                pad_out = IS_CAN_TX ? can_tx : 1'b0;
            end
            OWN_I2C: begin
                pad_oe  = i2c_oe[I2C_IDX];
                pad_out = i2c_out[I2C_IDX];
            end
            OWN_UART: begin
                pad_oe  = IS_UART_TX;
                pad_out = IS_UART_TX ? uart_tx : 1'b0;
            end
            default: begin
                pad_oe  = dir_bit;
                pad_out = dat_bit;
            end
        endcase
    end

endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
    import gpio_ovr_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter logic [WIDTH-1:0] UNIMPL_MASK = 8'h08,
    parameter int CAN_TX_PIN  = 7,
    parameter int CAN_RX_PIN  = 6,
    parameter int I2C_PIN_LO  = 6,
    parameter int I2C_PIN_HI  = 7,
    parameter int UART_TX_PIN = 1,
    parameter int UART_RX_PIN = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    input  logic             can_en,
    input  logic             can_tx,
    input  logic             i2c_en,
    input  logic [1:0]       i2c_oe,
    input  logic [1:0]       i2c_out,
    input  logic             uart_tx_en,
    input  logic             uart_rx_en,
    input  logic             uart_tx
);

    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] dat_q;
    logic [WIDTH-1:0] sync_q;
    pin_owner_e       owner [WIDTH];

    gpio_ovr_regs #(.WIDTH(WIDTH), .UNIMPL_MASK(UNIMPL_MASK)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .dir_q   (dir_q),
        .dat_q   (dat_q)
    );

    gpio_ovr_sync #(.WIDTH(WIDTH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .sync_q (sync_q)
    );

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        gpio_ovr_pin #(
            .PIN         (p),
            .CAN_TX_PIN  (CAN_TX_PIN),
            .CAN_RX_PIN  (CAN_RX_PIN),
            .I2C_PIN_LO  (I2C_PIN_LO),
            .I2C_PIN_HI  (I2C_PIN_HI),
            .UART_TX_PIN (UART_TX_PIN),
            .UART_RX_PIN (UART_RX_PIN)
        ) u_pin (
            .dir_bit    (dir_q[p]),
            .dat_bit    (dat_q[p]),
            .can_en     (can_en),
            .can_tx     (can_tx),
            .i2c_en     (i2c_en),
            .i2c_oe     (i2c_oe),
            .i2c_out    (i2c_out),
            .uart_tx_en (uart_tx_en),
            .uart_rx_en (uart_rx_en),
            .uart_tx    (uart_tx),
            .pad_out    (pad_out[p]),
            .pad_oe     (pad_oe[p]),
            .owner      (owner[p])
        );
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_DIR:   rd_data = dir_q;
            ADDR_DATA:  rd_data = (dat_q & pad_oe) | (sync_q & ~pad_oe);
            ADDR_INPUT: rd_data = sync_q;
            default:    rd_data = '0;
        endcase
    end

    // R5: CAN drives its transmit pin and releases its receive pin
    p_can_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
        can_en |-> (pad_oe[CAN_TX_PIN] && !pad_oe[CAN_RX_PIN]
                    && pad_out[CAN_TX_PIN] == can_tx));

    // R6: I2C owns its pins when CAN is off
    p_i2c_owns_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (i2c_en && !can_en) |-> (pad_oe[I2C_PIN_HI] == i2c_oe[1]
                                 && pad_out[I2C_PIN_LO] == i2c_out[0]));

    // R7: UART transmit and receive pins are forced independently
    p_uart_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        uart_tx_en |-> (pad_oe[UART_TX_PIN] && pad_out[UART_TX_PIN] == uart_tx));
    p_uart_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        uart_rx_en |-> !pad_oe[UART_RX_PIN]);

    // R8: CAN wins over I2C on the shared receive pin
    p_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (can_en && i2c_en) |-> (!pad_oe[CAN_RX_PIN] && !pad_out[CAN_RX_PIN]));

endmodule

// File: tb/gpio_ovr_port_bench.sv
`timescale 1ns/1ps
module gpio_ovr_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic       can_en = 0, can_tx = 0, i2c_en = 0;
    logic [1:0] i2c_oe = '0, i2c_out = '0;
    logic       uart_tx_en = 0, uart_rx_en = 0, uart_tx = 0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    gpio_ovr_port u_gpio_ovr_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .can_en(can_en), .can_tx(can_tx), .i2c_en(i2c_en),
        .i2c_oe(i2c_oe), .i2c_out(i2c_out), .uart_tx_en(uart_tx_en),
        .uart_rx_en(uart_rx_en), .uart_tx(uart_tx)
    );

    // {dir, dat, can_en, can_tx, i2c_en, i2c_oe, i2c_out, utx_en, urx_en, utx, exp_oe, exp_out}
    localparam logic [41:0] VEC [0:7] = '{
        {8'hFF, 8'hA5, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 8'hF7, 8'hA5},
        {8'h00, 8'hFF, 1'b1, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 8'h80, 8'hBF},
        {8'h0F, 8'h00, 1'b0, 1'b0, 1'b1, 2'b10, 2'b01, 1'b0, 1'b0, 1'b0, 8'h87, 8'h40},
        {8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 2'b01, 2'b11, 1'b0, 1'b0, 1'b0, 8'h80, 8'h00},
        {8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b1, 1'b0, 1'b1, 8'h02, 8'h02},
        {8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 8'hF6, 8'hFE},
        {8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 8'hF6, 8'h00},
        {8'h5A, 8'h3C, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 8'h52, 8'h3C}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 oe in reset", pad_oe, 8'h00);
        rd_addr = 2'd0; #1;
        chk("R1 dir in reset", rd_data, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 oe after reset", pad_oe, 8'h00);
        rd_addr = 2'd1; #1;
        chk("R1 data after reset", rd_data, 8'h00);

        // table walk: R2 R3 R5 R6 R7 R8
        for (int i = 0; i < 8; i++) begin
            logic [41:0] v;
            v = VEC[i];
            @(negedge clk);
            can_en = v[25]; can_tx = v[24]; i2c_en = v[23];
            i2c_oe = v[22:21]; i2c_out = v[20:19];
            uart_tx_en = v[18]; uart_rx_en = v[17]; uart_tx = v[16];
            bus_wr(2'd0, v[41:34]);
            bus_wr(2'd1, v[33:26]);
            rd_addr = 2'd0; #1;
            chk($sformatf("R2/R5/R6/R7/R8 vec%0d pad_oe", i), pad_oe, v[15:8]);
            chk($sformatf("R2/R5/R6/R7/R8 vec%0d pad_out", i), pad_out, v[7:0]);
            chk($sformatf("R3 vec%0d dir readback", i), rd_data, v[41:34] & 8'hF7);
        end

        // R9: override leaves the stored direction intact
        @(negedge clk);
        can_en = 0; i2c_en = 0; uart_tx_en = 0; uart_rx_en = 0;
        bus_wr(2'd0, 8'hFF);
        can_en = 1'b1; #1;
        chk("R9 oe under CAN", pad_oe, 8'hB7);
        rd_addr = 2'd0; #1;
        chk("R9 dir unchanged", rd_data, 8'hF7);
        @(negedge clk); can_en = 1'b0; #1;
        chk("R9 oe restored", pad_oe, 8'hF7);

        // R10: two-edge input synchronizer
        bus_wr(2'd0, 8'h00);
        rd_addr = 2'd2;
        repeat (3) @(negedge clk);
        pad_in = 8'h3C;
        @(negedge clk);
        chk("R10 after one edge", rd_data, 8'h00);
        @(negedge clk);
        chk("R10 after two edges", rd_data, 8'h3C);

        // R11: data read mixes latch and pad levels
        bus_wr(2'd0, 8'hF0);
        bus_wr(2'd1, 8'hAA);
        pad_in = 8'h55;
        repeat (3) @(negedge clk);
        rd_addr = 2'd1; #1;
        chk("R11 mixed data read", rd_data, 8'hA5);

        // R4: address map and unimplemented location
        rd_addr = 2'd0; #1;
        chk("R4 dir read", rd_data, 8'hF0);
        rd_addr = 2'd3; #1;
        chk("R4 address 3 reads 0", rd_data, 8'h00);

        // R3: writing only bit 3 leaves it clear and pin 3 an input
        bus_wr(2'd0, 8'h08);
        rd_addr = 2'd0; #1;
        chk("R3 bit 3 ignored", rd_data, 8'h00);
        chk("R3 pin 3 oe", pad_oe, 8'h00);

        finish_run();
    end

endmodule